// File: doc/BRIEF.md
# RX/TX FIFO Memory-Burst Request Controller

This controller sits beside the receive and transmit FIFOs of a network MAC. It decides when the receive side should claim the shared memory bus, and when the transmit side may start sending a frame to the PHY. It does not move any data itself. It watches the FIFO fill levels against programmable byte thresholds. It raises a bus request to the memory arbiter and, once granted, issues one burst command of a programmable byte length on a valid/ready channel.

A programmable countdown starts each time a request is raised. If the grant has not arrived when the countdown runs out, the request is flagged high priority. All settings live in one 16-bit control word. That word can only be rewritten while reception is disabled.

The burst command is a valid/ready channel. `move_valid` rises the cycle after the grant. `move_valid` and `move_len` then hold steady until `move_ready` is seen high at a clock edge. `move_ready` may stall for any number of cycles. The request stays up until that handshake completes. In the cycle after the handshake the controller is idle and compares the RX level against the threshold again.

Top module: `fifo_burst_req_ctrl`

## Requirements
- R1: After reset the control word reads 0x0F1A. This means a wait of 15 clocks, RX code 01, TX code 10 and burst code 10. After reset `bus_req`, `bus_hipri`, `move_valid` and `tx_start` are all low.
- R2: Only bits 12..8 (wait count), 5..4 (RX code), 3..2 (TX code) and 1..0 (burst code) are writable. All other bits read as zero, so writing 0xFFFF reads back 0x1F3F.
- R3: A write made while `rx_enable` is high is ignored, and the control word keeps its old value.
- R4: With `rx_enable` high and the controller idle, `bus_req` rises one cycle after `rx_level` reaches the RX threshold. The RX threshold is 8 bytes for code 00, 16 for 01, 32 for 10 and 64 for 11. Below the threshold, no request is raised.
- R5: If the wait count is N > 0, `bus_hipri` is low for the first N cycles of the request. It goes high in cycle N, counting the cycle where `bus_req` rose as cycle 0, provided no grant has come.
- R6: The cycle after `bus_gnt` is seen with the request up, `bus_hipri` is low and `move_valid` is high.
- R7: `move_len` equals the burst length: 4 bytes for code 00, 8 for 01, 16 for 10 and 32 for 11.
- R8: With a wait count of 0, `bus_hipri` is high in the same cycle `bus_req` rises.
- R9: While `move_ready` is low, `move_valid`, `move_len` and `bus_req` hold.
- R10: One cycle after the `move_ready` handshake, `bus_req` and `move_valid` are low. If the level is still at or above the threshold, a fresh request follows one cycle later, with the countdown reloaded.
- R11: `tx_start` rises one cycle after `tx_level` reaches the TX threshold. The TX threshold is 16 bytes for code 00, 32 for 01, 64 for 10 and 96 for 11. It then stays high even if `tx_level` falls.
- R12: `tx_start` drops one cycle after `tx_frame_end` is pulsed. The frame end takes priority over a level that is still above the threshold in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Current control word |
| rx_enable | input | 1 | Reception enabled; locks the control word |
| rx_level | input | LVL_W (8) | Bytes held in the RX FIFO |
| tx_level | input | LVL_W (8) | Bytes held in the TX FIFO |
| tx_frame_end | input | 1 | Pulse: current TX frame fully sent |
| tx_start | output | 1 | TX side may start sending to the PHY |
| bus_req | output | 1 | Memory bus request |
| bus_hipri | output | 1 | Request is high priority |
| bus_gnt | input | 1 | Memory bus grant |
| move_valid | output | 1 | Burst command valid |
| move_ready | input | 1 | Burst command accepted |
| move_len | output | 6 | Burst length in bytes |

## Verification
Two functions can fall in the same cycle. First, the escalation countdown can expire in the very cycle the grant arrives. The bench drives `bus_gnt` exactly in the cycle where `bus_hipri` first goes high. It then expects `bus_hipri` low and `move_valid` high one cycle later. Second, `tx_frame_end` can coincide with a TX level still above the threshold. The bench holds the level high while pulsing the frame end. It judges that `tx_start` falls on the next cycle, and only returns one cycle after that.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef struct packed {
    logic [4:0] wait_clks;
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic [1:0] burst_code;
  } fbr_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_MOVE = 2'd2
  } fbr_state_t;

  localparam logic [15:0] CFG_RESET = 16'h0F1A;
  localparam logic [15:0] CFG_MASK  = 16'h1F3F;

  function automatic logic [7:0] rx_thresh_bytes(input logic [1:0] code);
    return 8'd8 << code;
  endfunction

  function automatic logic [7:0] burst_bytes(input logic [1:0] code);
    return 8'd4 << code;
  endfunction

  function automatic logic [7:0] tx_thresh_bytes(input logic [1:0] code);
    logic [7:0] v;
    case (code)
      2'd0:    v = 8'd16;
      2'd1:    v = 8'd32;
      2'd2:    v = 8'd64;
      default: v = 8'd96;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/fbr_cfg_reg.sv
module fbr_cfg_reg
  import fbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  input  logic        lock,
  output fbr_cfg_t    cfg,
  output logic [15:0] rdata
);
  logic [15:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= CFG_RESET;
    else if (we && !lock)
      word_q <= wdata & CFG_MASK;
  end

  assign rdata          = word_q;
  assign cfg.wait_clks  = word_q[12:8];
  assign cfg.rx_code    = word_q[5:4];
  assign cfg.tx_code    = word_q[3:2];
  assign cfg.burst_code = word_q[1:0];
endmodule

// File: rtl/fbr_prio_timer.sv
module fbr_prio_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fbr_tx_kick.sv
module fbr_tx_kick #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             frame_end,
  output logic             start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      start <= 1'b0;
    else if (frame_end)
      start <= 1'b0;
    else if (level >= thresh)
      start <= 1'b1;
  end
endmodule

// File: rtl/fifo_burst_req_ctrl.sv
module fifo_burst_req_ctrl
  import fbr_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int LEN_W   = 6,
  parameter int WAIT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             rx_enable,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_frame_end,
  output logic             tx_start,
  output logic             bus_req,
  output logic             bus_hipri,
  input  logic             bus_gnt,
  output logic             move_valid,
  input  logic             move_ready,
  output logic [LEN_W-1:0] move_len
);
  fbr_cfg_t   cfg;
  fbr_state_t state_q, state_d;
  logic       rx_hit;
  logic       tmr_expired;
  logic [LVL_W-1:0] rx_thr;
  logic [LVL_W-1:0] tx_thr;

  fbr_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .lock  (rx_enable),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  assign rx_thr = LVL_W'(rx_thresh_bytes(cfg.rx_code));
  assign tx_thr = LVL_W'(tx_thresh_bytes(cfg.tx_code));
  assign rx_hit = rx_enable && (rx_level >= rx_thr);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (rx_hit)     state_d = ST_REQ;
      ST_REQ:  if (bus_gnt)    state_d = ST_MOVE;
      ST_MOVE: if (move_ready) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

  fbr_prio_timer #(.W(WAIT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state_q == ST_IDLE && rx_hit),
    .load_val (WAIT_W'(cfg.wait_clks)),
    .run      (state_q == ST_REQ && !bus_gnt),
    .expired  (tmr_expired)
  );

  fbr_tx_kick #(.LVL_W(LVL_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (tx_level),
    .thresh    (tx_thr),
    .frame_end (tx_frame_end),
    .start     (tx_start)
  );

  assign bus_req    = (state_q == ST_REQ) || (state_q == ST_MOVE);
  assign bus_hipri  = (state_q == ST_REQ) && tmr_expired;
  assign move_valid = (state_q == ST_MOVE);
  assign move_len   = LEN_W'(burst_bytes(cfg.burst_code));
endmodule

// File: rtl/fifo_burst_req_ctrl_chk.sv
module fifo_burst_req_ctrl_chk #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      cfg_rdata,
  input logic             rx_enable,
  input logic             tx_frame_end,
  input logic             tx_start,
  input logic             bus_req,
  input logic             bus_hipri,
  input logic             bus_gnt,
  input logic             move_valid,
  input logic             move_ready,
  input logic [LEN_W-1:0] move_len
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~16'h1F3F) == 16'h0000); // R2

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |=> $stable(cfg_rdata)); // R3

  AST_HIPRI_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hipri |-> bus_req); // R5

  AST_GRANT_TO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !move_valid && bus_gnt) |=> (move_valid && !bus_hipri)); // R6

  AST_MOVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (move_valid && !move_ready) |=> (move_valid && bus_req && $stable(move_len))); // R9

  AST_MOVE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (move_valid && move_ready) |=> (!move_valid && !bus_req)); // R10

  AST_TX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !tx_frame_end) |=> tx_start); // R11

  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_end |=> !tx_start); // R12
endmodule

bind fifo_burst_req_ctrl fifo_burst_req_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rdata    (cfg_rdata),
  .rx_enable    (rx_enable),
  .tx_frame_end (tx_frame_end),
  .tx_start     (tx_start),
  .bus_req      (bus_req),
  .bus_hipri    (bus_hipri),
  .bus_gnt      (bus_gnt),
  .move_valid   (move_valid),
  .move_ready   (move_ready),
  .move_len     (move_len)
);

// File: tb/sim_fifo_burst_req_ctrl.sv
module sim_fifo_burst_req_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        rx_enable = 1'b0;
  logic [7:0]  rx_level = '0;
  logic [7:0]  tx_level = '0;
  logic        tx_frame_end = 1'b0;
  logic        tx_start;
  logic        bus_req, bus_hipri;
  logic        bus_gnt = 1'b0;
  logic        move_valid;
  logic        move_ready = 1'b0;
  logic [5:0]  move_len;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fifo_burst_req_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_enable(rx_enable), .rx_level(rx_level),
    .tx_level(tx_level), .tx_frame_end(tx_frame_end), .tx_start(tx_start),
    .bus_req(bus_req), .bus_hipri(bus_hipri), .bus_gnt(bus_gnt),
    .move_valid(move_valid), .move_ready(move_ready), .move_len(move_len)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    rx_enable = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = w;
    step();
    cfg_we = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    check(cfg_rdata == 16'h0F1A, "R1 cfg", cfg_rdata, 16'h0F1A);
    check({bus_req, bus_hipri, move_valid, tx_start} == 4'b0, "R1 outs",
          {bus_req, bus_hipri, move_valid, tx_start}, 0);
  endtask

  // R2 R3
  task automatic t_cfg_access();
    write_cfg(16'hFFFF);
    check(cfg_rdata == 16'h1F3F, "R2 mask", cfg_rdata, 16'h1F3F);
    rx_enable = 1'b1;
    cfg_we = 1'b1;
    cfg_wdata = 16'h0000;
    step();
    cfg_we = 1'b0;
    step();
    check(cfg_rdata == 16'h1F3F, "R3 locked", cfg_rdata, 16'h1F3F);
    rx_enable = 1'b0;
    step();
  endtask

  // R4 R5 R6 R7: wait=3, rx code 10 (32 B), burst code 01 (8 B)
  task automatic t_threshold_escalate();
    write_cfg(16'h0321);
    rx_enable = 1'b1;
    rx_level = 8'd31;
    step(); step(); step();
    check(!bus_req, "R4 below", bus_req, 0);
    rx_level = 8'd32;
    step();
    check(bus_req, "R4 at thr", bus_req, 1);
    check(!bus_hipri, "R5 k0", bus_hipri, 0);
    step();
    check(!bus_hipri, "R5 k1", bus_hipri, 0);
    step();
    check(!bus_hipri, "R5 k2", bus_hipri, 0);
    step();
    check(bus_hipri, "R5 k3", bus_hipri, 1);
    bus_gnt = 1'b1;      // grant in the same cycle as escalation
    step();
    bus_gnt = 1'b0;
    check(!bus_hipri, "R6 hipri clr", bus_hipri, 0);
    check(move_valid, "R6 move", move_valid, 1);
    check(move_len == 6'd8, "R7 len01", move_len, 8);
    rx_level = 8'd0;
    move_ready = 1'b1;
    step();
    move_ready = 1'b0;
    check(!bus_req && !move_valid, "R10 idle", bus_req, 0);
    rx_enable = 1'b0;
    step();
  endtask

  // R8
  task automatic t_zero_wait();
    write_cfg(16'h0012);
    rx_enable = 1'b1;
    rx_level = 8'd16;
    step();
    check(bus_req && bus_hipri, "R8 immediate", {bus_req, bus_hipri}, 3);
    bus_gnt = 1'b1;
    step();
    bus_gnt = 1'b0;
    check(move_len == 6'd16, "R7 len10", move_len, 16);
    rx_level = 8'd0;
    move_ready = 1'b1;
    step();
    move_ready = 1'b0;
    rx_enable = 1'b0;
    step();
  endtask

  // R9 R10 R7: wait=2, rx code 00 (8 B), burst code 11 (32 B)
  task automatic t_backpressure();
    write_cfg(16'h0203);
    rx_enable = 1'b1;
    rx_level = 8'd8;
    step();
    bus_gnt = 1'b1;
    step();
    bus_gnt = 1'b0;
    check(move_len == 6'd32, "R7 len11", move_len, 32);
    for (int i = 0; i < 3; i++) begin
      step();
      check(move_valid && bus_req && move_len == 6'd32, "R9 hold",
            {move_valid, bus_req}, 3);
    end
    move_ready = 1'b1;
    step();
    move_ready = 1'b0;
    check(!move_valid && !bus_req, "R10 release", {move_valid, bus_req}, 0);
    step();
    check(bus_req && !bus_hipri, "R10 rerequest", {bus_req, bus_hipri}, 2);
    step();
    check(!bus_hipri, "R10 reload k1", bus_hipri, 0);
    step();
    check(bus_hipri, "R10 reload k2", bus_hipri, 1);
    bus_gnt = 1'b1;
    step();
    bus_gnt = 1'b0;
    rx_level = 8'd0;
    move_ready = 1'b1;
    step();
    move_ready = 1'b0;
    rx_enable = 1'b0;
    step();
  endtask

  // R7 code 00
  task automatic t_len_min();
    write_cfg(16'h0000);
    check(move_len == 6'd4, "R7 len00", move_len, 4);
  endtask

  // R11 R12: tx code 11 (96 B)
  task automatic t_tx();
    write_cfg(16'h000C);
    tx_level = 8'd95;
    step(); step();
    check(!tx_start, "R11 below", tx_start, 0);
    tx_level = 8'd96;
    step();
    check(tx_start, "R11 at thr", tx_start, 1);
    tx_level = 8'd0;
    step(); step();
    check(tx_start, "R11 sticky", tx_start, 1);
    tx_level = 8'd100;
    tx_frame_end = 1'b1;
    step();
    tx_frame_end = 1'b0;
    check(!tx_start, "R12 clear", tx_start, 0);
    step();
    check(tx_start, "R12 rearm", tx_start, 1);
    tx_frame_end = 1'b1;
    tx_level = 8'd0;
    step();
    tx_frame_end = 1'b0;
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_cfg_access();
    t_threshold_escalate();
    t_zero_wait();
    t_backpressure();
    t_len_min();
    t_tx();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule